// File: doc/BRIEF.md
# SPI Memory Write Sequencer with Automatic Write Enable

This block acts as an SPI master for one complete write to a serial nonvolatile memory. A single request starts two chip-select frames. The first frame carries only the write-enable command. After chip select has been high for a minimum gap, the second frame carries the write opcode, a one- or two-byte address, and the data bytes. The data bytes come from a valid/ready byte stream. Software above this block never sends the write-enable step itself: every write gets one.

The data stream is back-pressured one byte at a time. `din_ready` is high only while the data phase is waiting for its next byte. A byte moves on the cycle where `din_valid` and `din_ready` are both high. If the source stalls, the frame stays open: chip select remains low and SCK stays low until the next byte arrives. The block only captures data at the handshake, so the source may change `din_data` freely while `din_valid` is low. The request port is plain control. A request is taken only when the block is idle and the length is nonzero.

Top module: `spi_wr_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `din_ready` are 0.
- R2: An accepted request raises `busy` in the next cycle. The first frame holds exactly one byte, 0x06, and `spi_cs_n` then returns high.
- R3: Between the two frames of a write, `spi_cs_n` stays high for at least CS_GAP (2 or more) system cycles. After the end of one write, it also stays high for at least 2 cycles before the next write starts.
- R4: The second frame starts with byte 0x02. When `req_wide`=1 it then sends `req_addr[15:8]` and then `req_addr[7:0]`; when `req_wide`=0 it sends only `req_addr[7:0]`. After the address come exactly `req_len` data bytes, in the order they were accepted.
- R5: Bytes are sent MSB first in SPI mode 0:
  - `spi_mosi` never changes on the edge where `spi_sck` rises, nor while `spi_sck` is high.
  - Each SCK high phase lasts HALF_DIV system cycles.
  - `spi_sck` is 0 whenever `spi_cs_n` is 1.
  - Every frame holds a whole number of bytes.
- R6: While the data phase waits for a byte (`din_ready`=1, `din_valid`=0), `spi_cs_n` stays 0 and `spi_sck` stays 0.
- R7: `done` is high for exactly one cycle per write, in the first cycle after the final rise of `spi_cs_n`. `busy` is 0 in the following cycle.
- R8: `din_ready` is high only while `busy` is high. Each handshake uses up exactly one byte, so a write accepts exactly `req_len` bytes.
- R9: A request with `req_len`=0, or any request made while `busy`=1, has no effect: the frames in progress are unchanged and no extra write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a write (taken only when idle) |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W | Number of data bytes, 1 or more |
| req_wide | input | 1 | 1: two address bytes; 0: one address byte |
| din_data | input | 8 | Data byte from the stream |
| din_valid | input | 1 | Stream byte available |
| din_ready | output | 1 | Block takes a stream byte this cycle |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| busy | output | 1 | Write sequence in progress |
| done | output | 1 | One-cycle pulse when a write ends |

## Verification
The checker assumes a few things about its surroundings:
- Reset is asserted at start-up.
- CS_GAP is at least 2.
- The chip-select gap counter starts saturated, so the first frame after reset is not checked against a gap.

It does not assume the stream keeps `din_valid` high until the handshake, because the design only captures data at the handshake. The bench still behaves like a normal stream source. It raises `din_valid` only after a per-byte random delay, holds the byte until it is accepted, and then drops `din_valid` for at least one cycle. Spurious requests are sent only while a write is running, or with a zero length, so each one tests only the ignore rule.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WREN,
    PH_GAP,
    PH_OP,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_FIN
  } phase_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRITE = 8'h02;

endpackage

// File: rtl/spi_wr_shift.sv
// Shifts one byte out MSB first in SPI mode 0. SCK half period = HALF_DIV clocks.
module spi_wr_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_byte,
  output logic       idle,
  output logic       fin,
  output logic       sck,
  output logic       mosi
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sr_q;
  logic          act_q, sck_q, fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
      sr_q  <= '0;
      act_q <= 1'b0;
      sck_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (!act_q) begin
        if (ld) begin
          sr_q  <= ld_byte;
          act_q <= 1'b1;
          div_q <= '0;
          bit_q <= '0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          // Falling edge: advance to the next bit or finish the byte.
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sr_q  <= {sr_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign idle = !act_q;
  assign fin  = fin_q;
  assign sck  = sck_q;
  assign mosi = sr_q[7];

endmodule

// File: rtl/spi_wr_ctrl.sv
// Frame sequencer: write-enable frame, gap, then opcode/address/data frame.
module spi_wr_ctrl
  import spi_wr_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int CS_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wide,
  input  logic [7:0]       din_data,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic             sh_idle,
  input  logic             sh_fin,
  output logic             sh_ld,
  output logic [7:0]       sh_byte,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  phase_e           ph_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic             wide_q;
  logic             cs_q;
  logic [GW-1:0]    gap_q;
  logic             free;

  // The shifter may take a new byte only once its previous byte has retired.
  assign free = sh_idle && !sh_fin;

  always_comb begin
    sh_ld     = 1'b0;
    sh_byte   = 8'h00;
    din_ready = 1'b0;
    case (ph_q)
      PH_WREN: begin sh_ld = free; sh_byte = OPC_WREN;      end
      PH_OP:   begin sh_ld = free; sh_byte = OPC_WRITE;     end
      PH_AHI:  begin sh_ld = free; sh_byte = addr_q[15:8];  end
      PH_ALO:  begin sh_ld = free; sh_byte = addr_q[7:0];   end
      PH_DATA: begin
        din_ready = free;
        sh_ld     = free && din_valid;
        sh_byte   = din_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      left_q <= '0;
      wide_q <= 1'b0;
      cs_q   <= 1'b1;
      gap_q  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (req_valid && req_len != '0) begin
          addr_q <= req_addr;
          left_q <= req_len;
          wide_q <= req_wide;
          cs_q   <= 1'b0;
          ph_q   <= PH_WREN;
        end
        PH_WREN: if (sh_fin) begin
          cs_q  <= 1'b1;
          gap_q <= '0;
          ph_q  <= PH_GAP;
        end
        PH_GAP: begin
          if (gap_q == GAP_LAST) begin
            cs_q <= 1'b0;
            ph_q <= PH_OP;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        PH_OP:  if (sh_fin) ph_q <= wide_q ? PH_AHI : PH_ALO;
        PH_AHI: if (sh_fin) ph_q <= PH_ALO;
        PH_ALO: if (sh_fin) ph_q <= PH_DATA;
        PH_DATA: if (sh_fin) begin
          if (left_q == LEN_ONE) begin
            cs_q <= 1'b1;
            ph_q <= PH_FIN;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        PH_FIN: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cs_n = cs_q;
  assign busy = (ph_q != PH_IDLE);
  assign done = (ph_q == PH_FIN);

endmodule

// File: rtl/spi_wr_seq.sv
module spi_wr_seq #(
  parameter int LEN_W    = 8,
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wide,
  input  logic [7:0]       din_data,
  input  logic             din_valid,
  output logic             din_ready,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             busy,
  output logic             done
);
  logic       sh_idle, sh_fin, sh_ld;
  logic [7:0] sh_byte;

  spi_wr_ctrl #(
    .LEN_W  (LEN_W),
    .CS_GAP (CS_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wide  (req_wide),
    .din_data  (din_data),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .sh_idle   (sh_idle),
    .sh_fin    (sh_fin),
    .sh_ld     (sh_ld),
    .sh_byte   (sh_byte),
    .cs_n      (spi_cs_n),
    .busy      (busy),
    .done      (done)
  );

  spi_wr_shift #(
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (sh_ld),
    .ld_byte (sh_byte),
    .idle    (sh_idle),
    .fin     (sh_fin),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

endmodule

// File: rtl/spi_wr_seq_chk.sv
module spi_wr_seq_chk #(
  parameter int CS_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic din_valid,
  input logic din_ready,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic busy,
  input logic done
);
  // Counts consecutive high cycles of chip select (saturating).
  logic [7:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_q <= 8'hFF;
    else if (spi_cs_n) hi_q <= (hi_q == 8'hFF) ? hi_q : hi_q + 8'd1;
    else               hi_q <= 8'd0;
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_q >= 8'(CS_GAP))); // R3
  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R5
  AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R5
  AST_MOSI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && !din_valid) |=> (!spi_sck && !spi_cs_n)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> busy); // R8

endmodule

bind spi_wr_seq spi_wr_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .busy      (busy),
  .done      (done)
);

// File: tb/spi_wr_seq_tb.sv
module spi_wr_seq_tb;
  localparam int LW   = 8;
  localparam int HALF = 2;
  localparam int GAP  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_wide = 1'b0;
  logic [7:0]    din_data = '0;
  logic          din_valid = 1'b0;
  logic          din_ready, spi_cs_n, spi_sck, spi_mosi, busy, done;

  always #2.5 clk = ~clk;

  spi_wr_seq #(.LEN_W(LW), .HALF_DIV(HALF), .CS_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_wide(req_wide), .din_data(din_data),
    .din_valid(din_valid), .din_ready(din_ready), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .busy(busy), .done(done)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- SPI monitor ----------------
  logic [7:0] fb [0:3][0:63];
  int flen [0:3];
  int nfr, fl, nb, hrun, hcnt, gap_min, bad_sck, bad_idle, partial, ndone, done_bad;
  logic [7:0] cur;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (!spi_cs_n && spi_sck && !prev_sck) begin
      cur = {cur[6:0], spi_mosi};
      nb++;
      if (nb == 8) begin
        if (nfr < 4 && fl < 64) fb[nfr][fl] = cur;
        fl++;
        nb = 0;
      end
    end
    if (spi_sck) hrun++;
    else if (prev_sck) begin
      if (hrun != HALF) bad_sck++;
      hrun = 0;
    end
    if (spi_cs_n && spi_sck) bad_idle++;
    if (!prev_cs && spi_cs_n) begin
      if (nfr < 4) flen[nfr] = fl;
      if (nb != 0) partial++;
      nfr++;
      fl = 0;
      nb = 0;
    end
    if (prev_cs && !spi_cs_n && nfr > 0 && hcnt < gap_min) gap_min = hcnt;
    if (spi_cs_n) hcnt++; else hcnt = 0;
    if (done) ndone++;
    if (done && !spi_cs_n) done_bad++;
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  // ---------------- Stream source ----------------
  logic [7:0] dat [0:63];
  int dly [0:63];
  int feed_n = 0, idx = 0, wait_c = 0;
  bit feed_on = 1'b0, pend = 1'b0;

  always @(negedge clk) begin
    if (!feed_on) begin
      din_valid = 1'b0;
      pend = 1'b0;
    end else begin
      if (pend) begin
        idx++;
        din_valid = 1'b0;
        wait_c = 0;
      end else if (!din_valid && idx < feed_n) begin
        if (wait_c >= dly[idx]) begin
          din_valid = 1'b1;
          din_data  = dat[idx];
        end else begin
          wait_c++;
          if (idx >= 1 && dly[idx] >= 40 && wait_c == dly[idx]) begin
            chk(!spi_cs_n && !spi_sck && din_ready, "R6 stall holds frame open",
                {spi_cs_n, spi_sck, din_ready}, 3'b001);
          end
        end
      end
      pend = din_valid && din_ready;
    end
  end

  // ---------------- One write ----------------
  task automatic run_write(input logic [15:0] a, input int len, input bit wide,
                           input bit long_stall, input bit spurious);
    logic [7:0] exp [0:80];
    int k;
    int t;
    for (int i = 0; i < len; i++) begin
      dat[i] = 8'($urandom);
      dly[i] = long_stall ? ((i == 1) ? 60 : 0)
                          : (($urandom % 4 == 0) ? int'($urandom % 6) : 0);
    end
    nfr = 0; fl = 0; nb = 0; hrun = 0; gap_min = 1000; bad_sck = 0; bad_idle = 0;
    partial = 0; ndone = 0; done_bad = 0;
    idx = 0; wait_c = 0; feed_n = len; feed_on = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = LW'(len); req_wide = wide;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R2 busy after request", busy, 1);
    if (spurious) begin
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_addr = ~a; req_len = LW'(1); req_wide = ~wide;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R7 done seen", done, 1);
    @(negedge clk);
    chk(!busy && !done, "R7 busy low after done pulse", {busy, done}, 0);
    repeat (4) @(negedge clk);
    feed_on = 1'b0;
    exp[0] = 8'h02;
    k = 1;
    if (wide) begin exp[k] = a[15:8]; k++; end
    exp[k] = a[7:0]; k++;
    for (int i = 0; i < len; i++) begin exp[k] = dat[i]; k++; end
    chk(nfr == 2, spurious ? "R9 frame count with spurious request" : "R2 frame count", nfr, 2);
    chk(flen[0] == 1, "R2 enable frame length", flen[0], 1);
    chk(fb[0][0] == 8'h06, "R2 enable opcode", fb[0][0], 8'h06);
    chk(flen[1] == k, "R4 write frame length", flen[1], k);
    for (int i = 0; i < k && i < 64; i++)
      chk(fb[1][i] == exp[i], "R4 write frame byte", fb[1][i], exp[i]);
    chk(gap_min >= GAP, "R3 gap between frames", gap_min, GAP);
    chk(ndone == 1 && done_bad == 0, "R7 single done with cs high", ndone, 1);
    chk(bad_sck == 0 && bad_idle == 0 && partial == 0, "R5 sck shape and whole bytes",
        bad_sck + bad_idle + partial, 0);
    chk(idx == len, "R8 bytes consumed", idx, len);
    chk(spi_cs_n && !busy, "R9 no further write", {spi_cs_n, busy}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !busy && !done && !din_ready, "R1 reset outputs",
        {spi_cs_n, spi_sck, busy, done, din_ready}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !busy && !din_ready, "R1 idle after reset",
        {spi_cs_n, busy, din_ready}, 3'b100);

    // Zero-length request is ignored
    req_valid = 1'b1; req_addr = 16'h1234; req_len = '0; req_wide = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && spi_cs_n, "R9 zero length ignored", {busy, spi_cs_n}, 2'b01);

    // Directed corners
    run_write(16'h00A5, 1, 1'b0, 1'b0, 1'b0);
    run_write(16'hFFFF, 3, 1'b1, 1'b0, 1'b0);
    run_write(16'h8001, 4, 1'b1, 1'b1, 1'b0);
    run_write(16'h3C5A, 2, 1'b0, 1'b0, 1'b1);

    // Random writes
    for (int n = 0; n < 20; n++)
      run_write(16'($urandom), 1 + int'($urandom % 6), bit'($urandom % 2), 1'b0, (n % 5) == 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule